// File: doc/BRIEF.md
# Dual Interval Timers for an FM Sound Generator

This block provides two interval timers for an FM sound generator. Both are clocked by one internal tick that runs from reset and that software cannot stop or re-phase. Timer A has a 10-bit count and advances on every tick. Timer B has an 8-bit count and advances on every sixteenth tick, through a prescaler that nothing but reset ever clears. A host programs the count values and a control register through a small write port. It reads two overflow flags, and an interrupt line is raised while either flag is set.

Each timer is a small state machine with three states. CH_IDLE is stopped: ticks do nothing. CH_ARMED has seen its run bit set and waits for a tick. CH_RUN is counting. The transitions are named as follows. "start" moves CH_IDLE to CH_ARMED when the run bit is seen set. "load" moves CH_ARMED to CH_RUN on the timer's tick and copies the programmed count into the counter. "abort" moves CH_ARMED back to CH_IDLE if the run bit clears before that tick. "stop" moves CH_RUN to CH_IDLE when the run bit clears. "count" keeps CH_RUN in CH_RUN and increments the counter on a tick. "wrap" keeps CH_RUN in CH_RUN when the counter is at all ones on a tick: it reloads the counter and raises an overflow.

The register map has four registers on a 2-bit address:
- Address 0 is control: bit 0 run A, bit 1 flag-enable A, bit 2 clear flag A, bit 3 run B, bit 4 flag-enable B, bit 5 clear flag B. The two clear bits act only on the write that carries them and are not stored.
- Address 1 holds bits 9:2 of the timer A count.
- Address 2 holds bits 1:0 of the timer A count, in data bits 1:0.
- Address 3 holds the timer B count.

The status output carries timer A's flag in bit 0 and timer B's flag in bit 1.

Top module: `fm_dual_timer`

## Requirements
- R1: After reset both status flags and irq are 0, both timers are stopped, and the tick divider and the B prescaler start from zero.
- R2: While timer A runs with count value L = {address 1, address 2 bits 1:0}, it overflows once every 1024 - L ticks, and every overflow reloads the counter from the current count registers.
- R3: Writing a run bit as 1 when it was 0 does not load the counter at once. The arm is registered one clock after the write is captured, and the load happens at the first timer tick after that. The first overflow follows N timer ticks after the load, where N is the period.
- R4: Writing a count register while its timer runs does not change the current period. The new value is used from the next reload on.
- R5: While a run bit is 0 its timer neither counts nor sets its flag, even when its flag-enable bit is 1.
- R6: Rewriting a run bit that is already 1 does not arm a reload and does not move the next overflow.
- R7: A 0 to 1 run transition reloads the stored count even when no count register was written since the previous start.
- R8: With its flag-enable bit at 0 a running timer keeps counting on the same overflow grid but leaves its flag at 0.
- R9: A control write with a clear bit at 1 clears that timer's flag on the capturing clock. An overflow that occurs on the same clock wins, and the flag then stays 1.
- R10: While timer B runs with count value L, it overflows once every (256 - L) x 16 ticks.
- R11: The B prescaler advances on every tick and is never cleared by a load or a start. Every B overflow therefore falls on a fixed grid of 16 ticks, whenever timer B is started.
- R12: irq is 1 exactly while at least one status flag is 1.
- R13: The tick occurs once every TICK_DIV clocks and no register write changes its phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 control, 1 A high, 2 A low, 3 B |
| wr_data | input | 8 | Register write data |
| status | output | 2 | Overflow flags: bit 0 timer A, bit 1 timer B |
| irq | output | 1 | High while any overflow flag is set |

## Verification
A first run with the shortest periods measures the phase of the tick and of the B prescaler. Every later first overflow is then predicted to the exact clock. This tells a reload at the next tick apart from an immediate reload, and tells a free-running prescaler apart from one that restarts on each start.

Timer A runs with several stimulus patterns:
- count rewrites in mid-run, which separate a value used at once from one used only at the next reload;
- rewrites of a run bit that is already 1, and restarts with no new count;
- flag-enable turned off and back on, which shows whether counting continued unseen;
- a clear write placed on the very clock of an overflow, which fixes the set-over-clear priority.

Timer B is started at several offsets inside its prescaler period to show that its overflows stay on the same grid.

// File: rtl/fmt_pkg.sv
package fmt_pkg;

    // Register addresses
    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] REG_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] REG_A_HI = 2'd1;
    localparam logic [ADDR_W-1:0] REG_A_LO = 2'd2;
    localparam logic [ADDR_W-1:0] REG_B    = 2'd3;

    // Control register bit positions
    localparam int BIT_RUN_A = 0;
    localparam int BIT_FEN_A = 1;
    localparam int BIT_CLR_A = 2;
    localparam int BIT_RUN_B = 3;
    localparam int BIT_FEN_B = 4;
    localparam int BIT_CLR_B = 5;

    // Counter geometry
    localparam int DATA_W     = 8;
    localparam int A_W        = 10;
    localparam int A_LO_W     = A_W - DATA_W;
    localparam int B_W        = 8;
    localparam int B_PRE_BITS = 4;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_ARMED = 2'd1,
        CH_RUN   = 2'd2
    } ch_state_e;

    // Per-timer control as seen by a channel
    typedef struct packed {
        logic run;
        logic fen;
        logic clr;
    } ch_ctl_t;

endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
    parameter int TICK_DIV = 144
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] div_cnt;

    // Free-running divider: nothing but reset touches it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
        end else if (div_cnt == LAST) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    assign tick = (div_cnt == LAST);

    // R13: one tick, then a gap, and the divider restarts from zero
    p_tick_gap_r13: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (!tick && div_cnt == '0))
        else $error("tick not followed by gap");

    p_tick_step_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> (div_cnt == $past(div_cnt) + 1'b1))
        else $error("divider did not advance");

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import fmt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    output ch_ctl_t            ctl_a,
    output ch_ctl_t            ctl_b,
    output logic [A_W-1:0]     load_a,
    output logic [B_W-1:0]     load_b
);
    logic [DATA_W-1:0] a_hi;
    logic [A_LO_W-1:0] a_lo;
    logic [B_W-1:0]    b_val;
    logic              run_a, fen_a, run_b, fen_b;
    logic              wr_ctrl;

    assign wr_ctrl = wr_en && (wr_addr == REG_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_hi  <= '0;
            a_lo  <= '0;
            b_val <= '0;
            run_a <= 1'b0;
            fen_a <= 1'b0;
            run_b <= 1'b0;
            fen_b <= 1'b0;
        end else if (wr_en) begin
            unique case (wr_addr)
                REG_CTRL: begin
                    run_a <= wr_data[BIT_RUN_A];
                    fen_a <= wr_data[BIT_FEN_A];
                    run_b <= wr_data[BIT_RUN_B];
                    fen_b <= wr_data[BIT_FEN_B];
                end
                REG_A_HI: a_hi  <= wr_data;
                REG_A_LO: a_lo  <= wr_data[A_LO_W-1:0];
                REG_B:    b_val <= wr_data[B_W-1:0];
                default:  ;
            endcase
        end
    end

    // Clear requests are strobes taken straight from the write
    assign ctl_a  = '{run: run_a, fen: fen_a, clr: wr_ctrl && wr_data[BIT_CLR_A]};
    assign ctl_b  = '{run: run_b, fen: fen_b, clr: wr_ctrl && wr_data[BIT_CLR_B]};
    assign load_a = {a_hi, a_lo};
    assign load_b = b_val;

    // R3: the run bits follow the last control write
    p_run_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> (run_a == $past(wr_data[BIT_RUN_A]) &&
                     run_b == $past(wr_data[BIT_RUN_B])))
        else $error("run bits not captured");

    // R4: count values change only on their own writes
    p_count_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr != REG_CTRL) |=> ($stable(load_a) && $stable(load_b)))
        else $error("count value changed without a write");

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import fmt_pkg::*;
#(
    parameter int W        = 10,
    parameter int PRE_BITS = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  ch_ctl_t       ctl,
    input  logic [W-1:0]  load_val,
    output logic          flag
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    ch_state_e    state, state_nx;
    logic [W-1:0] cnt;
    logic         ch_tick;
    logic         ovf;

    // Tick source: direct, or through a prescaler that only reset clears
    generate
        if (PRE_BITS > 0) begin : g_pre
            logic [PRE_BITS-1:0] pre;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pre <= '0;
                end else if (tick) begin
                    pre <= pre + 1'b1;
                end
            end

            assign ch_tick = tick && (pre == {PRE_BITS{1'b1}});

            // R11: prescaler advances on every tick, whatever the state
            p_pre_free_r11: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> (pre == PRE_BITS'($past(pre) + 1'b1)))
                else $error("prescaler did not advance on tick");

            p_pre_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
                !tick |=> $stable(pre))
                else $error("prescaler moved without tick");
        end else begin : g_direct
            assign ch_tick = tick;
        end
    endgenerate

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= CH_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions: start, load, abort, stop, count/wrap
    always_comb begin
        state_nx = state;
        unique case (state)
            CH_IDLE: begin
                if (ctl.run) state_nx = CH_ARMED;          // start
            end
            CH_ARMED: begin
                if (!ctl.run)     state_nx = CH_IDLE;      // abort
                else if (ch_tick) state_nx = CH_RUN;       // load
            end
            CH_RUN: begin
                if (!ctl.run) state_nx = CH_IDLE;          // stop
            end
            default: state_nx = CH_IDLE;
        endcase
    end

    assign ovf = (state == CH_RUN) && ctl.run && ch_tick && (cnt == CNT_MAX);

    // Outputs: counter and flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            flag <= 1'b0;
        end else begin
            if (state == CH_ARMED && ctl.run && ch_tick) begin
                cnt <= load_val;
            end else if (state == CH_RUN && ctl.run && ch_tick) begin
                cnt <= ovf ? load_val : cnt + 1'b1;
            end

            if (ovf && ctl.fen) begin
                flag <= 1'b1;
            end else if (ctl.clr) begin
                flag <= 1'b0;
            end
        end
    end

    // R3: arming waits for a tick
    p_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_IDLE && ctl.run) |=> (state == CH_ARMED))
        else $error("start did not arm");

    p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_ARMED && ctl.run && ch_tick) |=>
            (state == CH_RUN && cnt == $past(load_val)))
        else $error("armed load missing");

    // R2: wrap reloads the programmed count
    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_RUN && ctl.run && ch_tick && cnt == CNT_MAX) |=>
            (cnt == $past(load_val)))
        else $error("wrap did not reload");

    // R4: counter moves only on its own tick
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_RUN && !ch_tick) |=> $stable(cnt))
        else $error("counter moved between ticks");

    // R5: stopped timer never raises its flag
    p_no_flag_stopped_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.run && !flag) |=> !flag)
        else $error("flag set while stopped");

    // R8: flag-enable off keeps the flag low
    p_no_flag_fen_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.fen && !flag) |=> !flag)
        else $error("flag set with flag-enable off");

    // R9: clear works unless an overflow lands on the same clock
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.clr && !ovf) |=> !flag)
        else $error("clear ignored");

endmodule

// File: rtl/fm_dual_timer.sv
module fm_dual_timer
    import fmt_pkg::*;
#(
    parameter int TICK_DIV = 144
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [7:0]  wr_data,
    output logic [1:0]  status,
    output logic        irq
);
    logic           tick;
    ch_ctl_t        ctl_a, ctl_b;
    logic [A_W-1:0] load_a;
    logic [B_W-1:0] load_b;
    logic           flag_a, flag_b;

    tmr_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    tmr_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ctl_a   (ctl_a),
        .ctl_b   (ctl_b),
        .load_a  (load_a),
        .load_b  (load_b)
    );

    tmr_channel #(.W(A_W), .PRE_BITS(0)) u_chan_a (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .ctl      (ctl_a),
        .load_val (load_a),
        .flag     (flag_a)
    );

    tmr_channel #(.W(B_W), .PRE_BITS(B_PRE_BITS)) u_chan_b (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .ctl      (ctl_b),
        .load_val (load_b),
        .flag     (flag_b)
    );

    assign status = {flag_b, flag_a};
    assign irq    = flag_a | flag_b;

    // R1: nothing set in the first cycle out of reset
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (status == 2'b00))
        else $error("flags set out of reset");

    // R12: a flag can only appear alongside a running timer
    p_flag_source_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(ctl_a.run) || $past(ctl_b.run)))
        else $error("irq without a running timer");

endmodule

// File: tb/tb_fm_dual_timer.sv
`timescale 1ns/1ps
module tb_fm_dual_timer;

    localparam int DIV  = 8;
    localparam int BPER = 16 * DIV;

    localparam logic [1:0] A_CTRL = 2'd0, A_AHI = 2'd1, A_ALO = 2'd2, A_B = 2'd3;
    localparam logic [7:0] RA = 8'h01, FA = 8'h02, CA = 8'h04;
    localparam logic [7:0] RB = 8'h08, FB = 8'h10, CB = 8'h20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] status;
    logic       irq;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int last_e = 0;
    int ph_a = 0;
    int ph_b = 0;
    int last_a = 0;
    bit done = 1'b0;

    fm_dual_timer #(.TICK_DIV(DIV)) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .status  (status),
        .irq     (irq)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Write; last_e = clock edge that captured it
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        last_e = cyc;
    endtask

    task automatic wait_flag(input int b, output int t);
        t = -1;
        for (int i = 0; i < 2000; i++) begin
            if (status[b]) begin
                t = cyc;
                break;
            end
            @(negedge clk);
        end
    endtask

    function automatic int next_at(input int from, input int ph, input int per);
        int t = from;
        while ((t % per) != ph) t++;
        return t;
    endfunction

    task automatic t_reset();
        chk(status == 2'b00, "R1 status after reset", int'(status), 0);
        chk(irq == 1'b0, "R1 irq after reset", int'(irq), 0);
    endtask

    task automatic t_calibrate();
        int ta = -1, tb = -1, e;
        wr(A_AHI, 8'hFF); wr(A_ALO, 8'h03); wr(A_B, 8'hFF);
        wr(A_CTRL, RA | FA | RB | FB);
        e = last_e;
        for (int i = 0; i < 1000 && (ta < 0 || tb < 0); i++) begin
            if (status[0] && ta < 0) ta = cyc;
            if (status[1] && tb < 0) tb = cyc;
            @(negedge clk);
        end
        chk(ta - e >= 2 + DIV && ta - e <= 1 + 2 * DIV, "R3 A first overflow window", ta - e, 2 + DIV);
        chk(tb - e >= 2 + BPER && tb - e <= 1 + 2 * BPER, "R3 B first overflow window", tb - e, 2 + BPER);
        ph_a = ta % DIV;
        ph_b = tb % BPER;
        wr(A_CTRL, CA | CB);
        chk(status == 2'b00, "R9 clear both flags", int'(status), 0);
    endtask

    task automatic t_a_period();
        int t1, t2, exp;
        wr(A_AHI, 8'hFA); wr(A_ALO, 8'h00);          // L = 1000, 24 ticks
        wr(A_CTRL, RA | FA);
        exp = next_at(last_e + 2, ph_a, DIV) + 24 * DIV;
        wait_flag(0, t1);
        chk(t1 == exp, "R3 A first overflow exact", t1, exp);
        wr(A_CTRL, RA | FA | CA);                    // 1->1 rewrite with clear
        chk(status[0] == 1'b0, "R9 A flag cleared", int'(status[0]), 0);
        wait_flag(0, t2);
        chk(t2 - t1 == 24 * DIV, "R2 A period", t2 - t1, 24 * DIV);
        last_a = t2;
    endtask

    task automatic t_count_write();
        int t3, t4, t5;
        wr(A_CTRL, RA | FA | CA);
        wr(A_AHI, 8'hFE);                            // L = 1016, 8 ticks
        wait_flag(0, t3);
        chk(t3 - last_a == 24 * DIV, "R4 running period unchanged", t3 - last_a, 24 * DIV);
        wr(A_CTRL, RA | FA | CA);
        wait_flag(0, t4);
        chk(t4 - t3 == 8 * DIV, "R4 new count at reload", t4 - t3, 8 * DIV);
        wr(A_CTRL, RA | FA | CA);
        t5 = t4 + 8 * DIV;
        while (cyc < t5 - 1) @(negedge clk);
        wr_en = 1'b1; wr_addr = A_CTRL; wr_data = RA | FA | CA;
        @(negedge clk);
        wr_en = 1'b0;
        chk(cyc == t5 && status[0] == 1'b1, "R9 overflow wins over clear", int'(status[0]), 1);
        last_a = t5;
    endtask

    task automatic t_stop();
        wr(A_CTRL, FA | CA);
        chk(status[0] == 1'b0, "R5 flag cleared on stop", int'(status[0]), 0);
        repeat (40 * DIV) @(negedge clk);
        chk(status[0] == 1'b0, "R5 no flag while stopped", int'(status[0]), 0);
    endtask

    task automatic t_reenable();
        int t, exp;
        wr(A_CTRL, RA | FA);
        exp = next_at(last_e + 2, ph_a, DIV) + 8 * DIV;
        wait_flag(0, t);
        chk(t == exp, "R7 restart reloads stored count", t, exp);
        chk(t % DIV == ph_a, "R13 tick phase kept", t % DIV, ph_a);
        last_a = t;
    endtask

    task automatic t_rewrite();
        int t;
        wr(A_CTRL, RA | FA | CA);
        repeat (3 * DIV) @(negedge clk);
        wr(A_CTRL, RA | FA);
        wait_flag(0, t);
        chk(t == last_a + 8 * DIV, "R6 rewrite does not rearm", t, last_a + 8 * DIV);
        last_a = t;
    endtask

    task automatic t_fen();
        int t;
        wr(A_CTRL, RA | CA);
        repeat (20 * DIV) @(negedge clk);
        chk(status[0] == 1'b0, "R8 no flag with enable off", int'(status[0]), 0);
        wr(A_CTRL, RA | FA);
        wait_flag(0, t);
        chk((t - last_a) % (8 * DIV) == 0, "R8 counting continued on grid", (t - last_a) % (8 * DIV), 0);
        wr(A_CTRL, CA);
        chk(status == 2'b00, "R9 clear after stop", int'(status), 0);
    endtask

    task automatic t_b_period();
        int t1, t2, exp;
        wr(A_B, 8'hFE);                              // 2 prescaled periods
        wr(A_CTRL, RB | FB);
        exp = next_at(last_e + 2, ph_b, BPER) + 2 * BPER;
        wait_flag(1, t1);
        chk(t1 == exp, "R11 B first overflow on prescaler grid", t1, exp);
        wr(A_CTRL, RB | FB | CB);
        wait_flag(1, t2);
        chk(t2 - t1 == 2 * BPER, "R10 B period", t2 - t1, 2 * BPER);
        wr(A_CTRL, CB);
    endtask

    task automatic t_b_phase();
        int offs[3] = '{5, 41, 97};
        for (int k = 0; k < 3; k++) begin
            int t, exp;
            wr(A_CTRL, CB);
            repeat (offs[k]) @(negedge clk);
            wr(A_CTRL, RB | FB);
            exp = next_at(last_e + 2, ph_b, BPER) + 2 * BPER;
            wait_flag(1, t);
            chk(t == exp, "R11 restart keeps prescaler phase", t, exp);
        end
        wr(A_CTRL, CB);
    endtask

    task automatic t_irq();
        int t;
        chk(irq == 1'b0, "R12 irq low with no flags", int'(irq), 0);
        wr(A_CTRL, RA | FA | RB | FB);
        wait_flag(0, t);
        chk(irq == 1'b1, "R12 irq with a flag set", int'(irq), 1);
        wr(A_CTRL, CA | CB);
        chk(status == 2'b00 && irq == 1'b0, "R12 irq drops after clears", int'(irq), 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_calibrate();
        t_a_period();
        t_count_write();
        t_stop();
        t_reenable();
        t_rewrite();
        t_fen();
        t_b_period();
        t_b_phase();
        t_irq();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule